// File: doc/BRIEF.md
# I2C Controller Command and Status Register Slice

This block is the control and status register slice of an I2C controller. On one side a CPU writes and reads a six-bit control word. On the other side sits a bit-level byte engine, which is not part of this block. The engine reports byte completions, address-phase completions and the controller's current role as event inputs. The slice holds three enables: acknowledge of data bytes, acknowledge of the general-call address, and interrupt. It also holds a transfer-end flag, which the engine sets. While that flag is set, the slice asks the engine to stretch SCL low.

A CPU write can clear the flag, request a repeated start, or drop the master-select bit. The slice turns each such write into exactly one command to the engine: next byte, repeated start or stop. When one write asks for more than one of these, a fixed priority picks the command. The slice also drives the interrupt request line. It picks the acknowledge level for the byte that the engine is currently receiving.

Control word bit positions: bit 0 transfer-end flag, bit 1 interrupt enable, bit 2 general-call acknowledge enable, bit 3 data acknowledge enable, bit 4 repeated-start request, bit 5 master select. Command codes on `cmd_kind`: 2'b01 next byte, 2'b10 repeated start, 2'b11 stop. Receive kinds on `rx_kind`: 2'b00 data byte, 2'b01 general-call address, 2'b10 own slave address, 2'b11 nothing being received.

Top module: `i2c_ctl_slice`

## Requirements
- R1: After synchronous reset every stored bit is 0, `rd_data` is 0, and `scl_hold`, `irq` and `cmd_valid` are all 0.
- R2: With `rx_kind`=2'b00, `ack_out` equals the data acknowledge enable (bit 3). With `rx_kind`=2'b10, `ack_out` equals the `addr_ack_en` input whatever bit 3 holds. With `rx_kind`=2'b11, `ack_out` is 0.
- R3: With `rx_kind`=2'b01, `ack_out` equals the general-call acknowledge enable (bit 2).
- R4: `irq` is 1 exactly when the interrupt enable (bit 1) and the transfer-end flag are both 1.
- R5: A `byte_end` pulse sets the flag on the next edge when at least one of `role_master`, `role_addressed`, `role_gcall` or `role_arb_lost` is 1. With none of them set, the flag does not change.
- R6: An `addr_byte_end` pulse with `addr_match`=1 sets the flag on the first address byte (`addr_second`=0) when `addr_ten_bit`=0, and on the second byte (`addr_second`=1) when `addr_ten_bit`=1. No other combination sets it.
- R7: `scl_hold` is 1 in every cycle in which the flag is 1, and 0 otherwise.
- R8: Writing 0 to bit 0 while the flag is 1 clears the flag and issues a next-byte command. Writing 1 to bit 0 leaves the flag unchanged.
- R9: When `rmw_rd` is 1, bit 0 of `rd_data` reads 1 whatever the flag holds. When `rmw_rd` is 0, it reads the flag. Bit 4 always reads 0.
- R10: Writing 1 to bit 4, or writing 0 to bit 5 while master select is 1, clears the flag and issues a command.
- R11: Each write that clears the flag or drops master select gives exactly one one-cycle `cmd_valid` pulse, in the cycle after the write. Stop beats repeated start, and repeated start beats next byte.
- R12: If a hardware set event and a clearing CPU write fall on the same edge, the flag ends up 1, and the write's command is still issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe for the control word |
| wr_data | input | 6 | Control word written by the CPU |
| rmw_rd | input | 1 | Marks the current read as part of a read-modify-write |
| rd_data | output | 6 | Control word as read by the CPU |
| byte_end | input | 1 | Engine finished a byte including its acknowledge bit |
| role_master | input | 1 | Controller is bus master |
| role_addressed | input | 1 | Controller is addressed as a slave |
| role_gcall | input | 1 | General-call address was received |
| role_arb_lost | input | 1 | Arbitration was lost |
| addr_byte_end | input | 1 | Engine finished an address byte including its acknowledge bit |
| addr_second | input | 1 | That address byte was the second one |
| addr_ten_bit | input | 1 | The current address uses 10-bit form |
| addr_match | input | 1 | The controller's own slave address was matched |
| rx_kind | input | 2 | Kind of byte now being received |
| addr_ack_en | input | 1 | Acknowledge enable for the own slave address |
| ack_out | output | 1 | Acknowledge level the engine should drive |
| scl_hold | output | 1 | Request to hold SCL low |
| irq | output | 1 | Interrupt request |
| cmd_valid | output | 1 | One-cycle command strobe to the engine |
| cmd_kind | output | 2 | Command code, valid with `cmd_valid` |

## Verification
The slice has no size parameters. Its widths come from package constants, so the bench builds it as it stands. At that size every one of the 64 control-word values can be written against both master-select states, with the flag set beforehand. This sweeps all priority combinations of stop, repeated start and next byte. It also covers the interrupt outcome each value gives. Further sweeps drive all 32 byte-end and role patterns, all 16 address-phase patterns, and all acknowledge-selection inputs. Directed cases cover a hardware set and a CPU clear landing on the same edge, and the read-modify-write view of the flag.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;

    localparam int CTL_W    = 6;
    localparam int ROLE_N   = 4;
    localparam int CMD_W    = 2;
    localparam int RX_W     = 2;

    localparam int B_FLAG   = 0;
    localparam int B_IEN    = 1;
    localparam int B_GCACK  = 2;
    localparam int B_DACK   = 3;
    localparam int B_RSTRT  = 4;
    localparam int B_MSEL   = 5;

    typedef enum logic [CMD_W-1:0] {
        CMD_NONE    = 2'b00,
        CMD_NEXT    = 2'b01,
        CMD_RESTART = 2'b10,
        CMD_STOP    = 2'b11
    } cmd_e;

    typedef enum logic [RX_W-1:0] {
        RX_DATA  = 2'b00,
        RX_GCALL = 2'b01,
        RX_OWN   = 2'b10,
        RX_IDLE  = 2'b11
    } rx_e;

    // Control word as seen on the CPU port, most significant bit first
    typedef struct packed {
        logic msel;
        logic rstrt;
        logic dack;
        logic gcack;
        logic ien;
        logic flag;
    } ctl_word_t;

    // Stored configuration bits
    typedef struct packed {
        logic msel;
        logic dack;
        logic gcack;
        logic ien;
    } cfg_t;

    // Fixed-priority choice of the single command a write produces
    function automatic cmd_e pick_cmd(
        input logic msel_now,
        input logic flag_now,
        input logic w_flag,
        input logic w_rstrt,
        input logic w_msel
    );
        if (msel_now && !w_msel)
            return CMD_STOP;
        else if (w_rstrt)
            return CMD_RESTART;
        else if (flag_now && !w_flag)
            return CMD_NEXT;
        else
            return CMD_NONE;
    endfunction

    // Address-phase completion that ends the slave address
    function automatic logic addr_phase_done(
        input logic match,
        input logic ten_bit,
        input logic second
    );
        return match && (ten_bit ? second : !second);
    endfunction

endpackage

// File: rtl/ctl_regfile.sv
module ctl_regfile
    import i2c_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  cfg_t wr_cfg,
    output cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q <= wr_cfg;
        end
    end

endmodule

// File: rtl/ctl_cmd_resolve.sv
module ctl_cmd_resolve
    import i2c_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_flag,
    input  logic wr_rstrt,
    input  logic wr_msel,
    input  logic msel_q,
    input  logic flag_q,
    output logic clear_req,
    output logic cmd_valid_q,
    output cmd_e cmd_kind_q
);

    cmd_e cmd_d;

    always_comb begin
        cmd_d = pick_cmd(msel_q, flag_q, wr_flag, wr_rstrt, wr_msel);
        if (!wr_en) begin
            cmd_d = CMD_NONE;
        end
        // Any flag-releasing write: a zero flag bit, a restart request or a master drop
        clear_req = wr_en && (!wr_flag || wr_rstrt || (msel_q && !wr_msel));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_valid_q <= 1'b0;
            cmd_kind_q  <= CMD_NONE;
        end else begin
            cmd_valid_q <= (cmd_d != CMD_NONE);
            cmd_kind_q  <= cmd_d;
        end
    end

    // R11: a command strobe only ever follows a CPU write
    a_r11_cmd_after_write: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_q |-> $past(wr_en));

    // R11: a stop only follows a write that dropped master select
    a_r11_stop_on_drop: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_q && cmd_kind_q == CMD_STOP) |-> ($past(msel_q) && !$past(wr_msel)));

    // R11: the strobe lasts one cycle unless another write followed
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_q && !wr_en) |=> !cmd_valid_q);

endmodule

// File: rtl/ctl_flag.sv
module ctl_flag
    import i2c_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_end,
    input  logic [ROLE_N-1:0] roles,
    input  logic              addr_byte_end,
    input  logic              addr_second,
    input  logic              addr_ten_bit,
    input  logic              addr_match,
    input  logic              clear_req,
    output logic              hw_set,
    output logic              flag_q
);

    logic byte_set;
    logic addr_set;

    always_comb begin
        byte_set = byte_end && (|roles);
        addr_set = addr_byte_end && addr_phase_done(addr_match, addr_ten_bit, addr_second);
        hw_set   = byte_set || addr_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (hw_set) begin
            flag_q <= 1'b1;
        end else if (clear_req) begin
            flag_q <= 1'b0;
        end
    end

    // R12: a hardware set always survives into the next cycle
    a_r12_set_wins: assert property (@(posedge clk) disable iff (rst)
        $past(hw_set) |-> flag_q);

    // R5: the flag only rises because of a hardware event
    a_r5_rise_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(hw_set));

    // R8: the flag only falls because of a clearing write
    a_r8_fall_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_q) |-> $past(clear_req));

endmodule

// File: rtl/ctl_ack_sel.sv
module ctl_ack_sel
    import i2c_ctl_pkg::*;
(
    input  rx_e  rx_kind,
    input  logic dack_en,
    input  logic gcack_en,
    input  logic own_ack_en,
    output logic ack
);

    always_comb begin
        unique case (rx_kind)
            RX_DATA:  ack = dack_en;
            RX_GCALL: ack = gcack_en;
            RX_OWN:   ack = own_ack_en;
            default:  ack = 1'b0;
        endcase
    end

endmodule

// File: rtl/i2c_ctl_slice.sv
module i2c_ctl_slice
    import i2c_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             rmw_rd,
    output logic [CTL_W-1:0] rd_data,
    input  logic             byte_end,
    input  logic             role_master,
    input  logic             role_addressed,
    input  logic             role_gcall,
    input  logic             role_arb_lost,
    input  logic             addr_byte_end,
    input  logic             addr_second,
    input  logic             addr_ten_bit,
    input  logic             addr_match,
    input  logic [RX_W-1:0]  rx_kind,
    input  logic             addr_ack_en,
    output logic             ack_out,
    output logic             scl_hold,
    output logic             irq,
    output logic             cmd_valid,
    output logic [CMD_W-1:0] cmd_kind
);

    ctl_word_t         wword;
    ctl_word_t         rword;
    cfg_t              wcfg;
    cfg_t              cfg_q;
    logic              flag_q;
    logic              hw_set;
    logic              clear_req;
    logic              cmd_valid_q;
    cmd_e              cmd_kind_q;
    logic [ROLE_N-1:0] roles;

    assign wword = ctl_word_t'(wr_data);
    assign roles = {role_arb_lost, role_gcall, role_addressed, role_master};

    always_comb begin
        wcfg.msel  = wword.msel;
        wcfg.dack  = wword.dack;
        wcfg.gcack = wword.gcack;
        wcfg.ien   = wword.ien;
    end

    ctl_regfile u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_cfg (wcfg),
        .cfg_q  (cfg_q)
    );

    ctl_cmd_resolve u_cmd (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_flag     (wword.flag),
        .wr_rstrt    (wword.rstrt),
        .wr_msel     (wword.msel),
        .msel_q      (cfg_q.msel),
        .flag_q      (flag_q),
        .clear_req   (clear_req),
        .cmd_valid_q (cmd_valid_q),
        .cmd_kind_q  (cmd_kind_q)
    );

    ctl_flag u_flag (
        .clk           (clk),
        .rst           (rst),
        .byte_end      (byte_end),
        .roles         (roles),
        .addr_byte_end (addr_byte_end),
        .addr_second   (addr_second),
        .addr_ten_bit  (addr_ten_bit),
        .addr_match    (addr_match),
        .clear_req     (clear_req),
        .hw_set        (hw_set),
        .flag_q        (flag_q)
    );

    ctl_ack_sel u_ack (
        .rx_kind    (rx_e'(rx_kind)),
        .dack_en    (cfg_q.dack),
        .gcack_en   (cfg_q.gcack),
        .own_ack_en (addr_ack_en),
        .ack        (ack_out)
    );

    always_comb begin
        rword.msel  = cfg_q.msel;
        rword.rstrt = 1'b0;
        rword.dack  = cfg_q.dack;
        rword.gcack = cfg_q.gcack;
        rword.ien   = cfg_q.ien;
        rword.flag  = flag_q || rmw_rd;
        rd_data     = rword;
        scl_hold    = flag_q;
        irq         = cfg_q.ien && flag_q;
        cmd_valid   = cmd_valid_q;
        cmd_kind    = cmd_kind_q;
    end

    // R4: an interrupt is only raised while the clock is being stretched
    a_r4_irq_needs_hold: assert property (@(posedge clk) disable iff (rst)
        irq |-> scl_hold);

    // R8: a command with no coincident set leaves SCL released
    a_r8_cmd_releases: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !$past(hw_set)) |-> !scl_hold);

    // R10: after a stop the master-select bit reads back as 0
    a_r10_stop_drops_master: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind == CMD_STOP) |-> !rd_data[B_MSEL]);

endmodule

// File: tb/i2c_ctl_slice_test.sv
`timescale 1ns/1ps
module i2c_ctl_slice_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [5:0] wr_data = '0;
    logic       rmw_rd = 1'b0;
    logic [5:0] rd_data;
    logic       byte_end = 1'b0;
    logic       role_master = 1'b0, role_addressed = 1'b0, role_gcall = 1'b0, role_arb_lost = 1'b0;
    logic       addr_byte_end = 1'b0, addr_second = 1'b0, addr_ten_bit = 1'b0, addr_match = 1'b0;
    logic [1:0] rx_kind = 2'b11;
    logic       addr_ack_en = 1'b0;
    logic       ack_out, scl_hold, irq, cmd_valid;
    logic [1:0] cmd_kind;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    i2c_ctl_slice uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rmw_rd(rmw_rd),
        .rd_data(rd_data), .byte_end(byte_end), .role_master(role_master),
        .role_addressed(role_addressed), .role_gcall(role_gcall),
        .role_arb_lost(role_arb_lost), .addr_byte_end(addr_byte_end),
        .addr_second(addr_second), .addr_ten_bit(addr_ten_bit),
        .addr_match(addr_match), .rx_kind(rx_kind), .addr_ack_en(addr_ack_en),
        .ack_out(ack_out), .scl_hold(scl_hold), .irq(irq),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One-cycle write; returns at the negedge after the capturing edge
    task automatic cpu_write(input logic [5:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic master_byte_done();
        @(negedge clk);
        byte_end = 1'b1; role_master = 1'b1;
        @(negedge clk);
        byte_end = 1'b0; role_master = 1'b0;
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [1:0] exp_cmd;
        logic       exp_flag;
        logic       exp_ack;
        logic       exp_set;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 rd_data", rd_data, 0);
        chk("R1 scl_hold", scl_hold, 0);
        chk("R1 irq", irq, 0);
        chk("R1 cmd_valid", cmd_valid, 0);

        // R8 R10 R11 R4 R7: every control word against both master states, flag set first
        for (int m = 0; m < 2; m++) begin
            for (int v = 0; v < 64; v++) begin
                cpu_write(m ? 6'h21 : 6'h01);
                idle(1);
                master_byte_done();
                chk("R5 set before sweep", scl_hold, 1);
                cpu_write(v[5:0]);
                if (m == 1 && !v[5])      exp_cmd = 2'b11;
                else if (v[4])            exp_cmd = 2'b10;
                else if (!v[0])           exp_cmd = 2'b01;
                else                      exp_cmd = 2'b00;
                exp_flag = (exp_cmd == 2'b00);
                chk("R11 cmd_valid", cmd_valid, exp_cmd != 2'b00);
                if (exp_cmd != 2'b00) chk("R11 cmd_kind", cmd_kind, exp_cmd);
                chk("R8 R10 flag", rd_data[0], exp_flag);
                chk("R7 scl_hold", scl_hold, exp_flag);
                chk("R4 irq", irq, v[1] & exp_flag);
                chk("R9 restart bit reads 0", rd_data[4], 0);
                @(negedge clk);
                chk("R11 one pulse", cmd_valid, 0);
            end
        end

        // Leave master mode, clear any flag
        cpu_write(6'h00);
        idle(2);

        // R5 byte-end and role patterns
        for (int p = 0; p < 32; p++) begin
            cpu_write(6'h00);
            idle(1);
            @(negedge clk);
            byte_end = p[4]; role_master = p[0]; role_addressed = p[1];
            role_gcall = p[2]; role_arb_lost = p[3];
            @(negedge clk);
            byte_end = 0; role_master = 0; role_addressed = 0; role_gcall = 0; role_arb_lost = 0;
            exp_set = p[4] & (|p[3:0]);
            chk("R5 byte-end set", scl_hold, exp_set);
        end

        // R6 address-phase patterns
        for (int p = 0; p < 16; p++) begin
            cpu_write(6'h00);
            idle(1);
            @(negedge clk);
            addr_byte_end = p[0]; addr_match = p[1]; addr_ten_bit = p[2]; addr_second = p[3];
            @(negedge clk);
            addr_byte_end = 0; addr_match = 0; addr_ten_bit = 0; addr_second = 0;
            exp_set = p[0] & p[1] & (p[2] ? p[3] : !p[3]);
            chk("R6 address set", scl_hold, exp_set);
        end

        // R2 R3 acknowledge selection sweep
        for (int d = 0; d < 2; d++) begin
            for (int g = 0; g < 2; g++) begin
                cpu_write({2'b00, d[0], g[0], 2'b01});
                for (int k = 0; k < 4; k++) begin
                    for (int a = 0; a < 2; a++) begin
                        rx_kind = k[1:0]; addr_ack_en = a[0];
                        #1;
                        case (k)
                            0: exp_ack = d[0];
                            1: exp_ack = g[0];
                            2: exp_ack = a[0];
                            default: exp_ack = 1'b0;
                        endcase
                        chk(k == 1 ? "R3 gcall ack" : "R2 ack select", ack_out, exp_ack);
                    end
                end
            end
        end
        rx_kind = 2'b11;

        // R9 read-modify-write view
        cpu_write(6'h00);
        idle(1);
        rmw_rd = 1'b1; #1;
        chk("R9 rmw reads 1", rd_data[0], 1);
        rmw_rd = 1'b0; #1;
        chk("R9 plain read", rd_data[0], 0);
        // R9 writing back the rmw value keeps the flag
        master_byte_done();
        cpu_write(6'h01);
        chk("R8 write 1 no effect", scl_hold, 1);
        chk("R8 write 1 no cmd", cmd_valid, 0);

        // R12 set and clear on the same edge
        @(negedge clk);
        wr_en = 1'b1; wr_data = 6'h00; byte_end = 1'b1; role_addressed = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; byte_end = 1'b0; role_addressed = 1'b0;
        chk("R12 flag kept", scl_hold, 1);
        chk("R12 cmd issued", cmd_valid, 1);
        chk("R12 cmd next", cmd_kind, 2'b01);

        // R1 reset clears stored state
        cpu_write(6'h2E);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 reset again", rd_data, 0);
        chk("R1 reset irq", irq, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule